// File: doc/BRIEF.md
# Multi-Resolution Complementary PWM Core

This block turns a base duty value of selectable width (5 to 9 bits) into a fixed-rate PWM waveform. Every width maps onto one common switching period of 513 clock cycles. A narrower duty is spread across that period by a shift, plus a small offset that centres each code in its step. A separate modulation block can ask for a one-count stretch of the next period's pulse through a single increment input. This is how dithering or dyadic fine resolution is layered on top of the base width.

The pulse request drives a dead-time stage. That stage produces a high-side and a low-side gate signal that are never on together, with a fixed gap where both are low around every edge. A square sync clock marks the switching rate. A five-bit debug bus shows the latched duty, normalised to the 9-bit domain.

Top module: `dpwm_core`

## Requirements
- R1: A period counter steps 0,1,…,512 and wraps to 0, so every switching period is exactly 513 clock cycles.
- R2: For width select s in 0..4 the width is B = s+5. The compare value is d·2^(9−B) + max(1, 2^(8−B)), where d is the low B bits of the duty. The high-side request is true while the counter is below the compare value.
- R3: Width select values 5, 6 and 7 behave exactly as select 3 (8-bit).
- R4: Duty bits at or above the selected width have no effect on any output.
- R5: Duty, width select and increment are sampled only on the clock edge where the counter leaves 512. The increment adds one to the compare value for the whole following period, and changes at any other time have no effect until then.
- R6: The high-side output is 1 only when the request was 1 on each of the previous 7 cycles. The low-side output is 1 only when the request was 0 on each of the previous 7 cycles. Both are therefore low for at least 6 cycles around every request change, and never high together.
- R7: While reset is low, both gate outputs are 0, the counter is 0, the latched compare value is 0 and the debug bus is 0.
- R8: The sync output is 1 while the counter is 0..256 and 0 while it is 257..512.
- R9: The debug bus equals bits [8:4] of d·2^(9−B) for the duty latched at the last period boundary, and is 0 until the first boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| duty_i | input | 9 | Base duty, low B bits used |
| width_sel_i | input | 3 | Width select, 0→5 bits … 4→9 bits |
| inc_i | input | 1 | +1 stretch request for the next period |
| hs_o | output | 1 | High-side gate |
| ls_o | output | 1 | Low-side gate |
| sync_o | output | 1 | Switching-rate square clock |
| duty_dbg_o | output | 5 | Normalised duty bits [8:4] |

## Verification
Inputs reach the outputs only at the edge where the counter wraps. The compare value and the debug bus take effect in the cycle after that edge. The request follows the counter with no extra delay. Each gate output lags the request by one register stage plus a six-cycle hold. The bench keeps its own counter, latched compare value and a seven-deep history of the request. It advances this model at each rising edge and compares the outputs at the falling edge. Gate checks start only once seven history entries exist after reset.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int MAX_BITS = 9;
  localparam int MIN_BITS = 5;
  localparam int PERIOD   = (1 << MAX_BITS) + 1;
  localparam int CNT_W    = $clog2(PERIOD);
  localparam int SEL_W    = 3;
  localparam int DBG_W    = 5;

  // width select to bit count; out-of-range codes fall back to 8 bits
  function automatic int unsigned sel_bits(logic [SEL_W-1:0] sel);
    if (int'(sel) > MAX_BITS - MIN_BITS) return 8;
    return int'(sel) + MIN_BITS;
  endfunction

  // duty shifted into the 9-bit domain, without offset
  function automatic int unsigned norm_duty(logic [MAX_BITS-1:0] duty,
                                            logic [SEL_W-1:0] sel);
    int unsigned b;
    int unsigned m;
    b = sel_bits(sel);
    m = int'(duty) & ((1 << b) - 1);
    return m << (MAX_BITS - b);
  endfunction

  // compare value: normalised duty plus centring offset
  function automatic logic [CNT_W-1:0] cmp_value(logic [MAX_BITS-1:0] duty,
                                                 logic [SEL_W-1:0] sel,
                                                 logic inc);
    int unsigned sh;
    int unsigned off;
    sh  = MAX_BITS - sel_bits(sel);
    off = (sh == 0) ? 1 : (1 << (sh - 1));
    return CNT_W'(norm_duty(duty, sel) + off + int'(inc));
  endfunction
endpackage

// File: rtl/dpwm_period_ctr.sv
module dpwm_period_ctr
  import dpwm_pkg::*;
#(
  parameter int P_PERIOD = PERIOD,
  localparam int W = $clog2(P_PERIOD),
  localparam int HALF = (P_PERIOD + 1) / 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o,
  output logic         sync_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = (cnt_q == W'(P_PERIOD - 1));
  assign cnt_o  = cnt_q;
  assign sync_o = (cnt_q < W'(HALF));

  always_ff @(posedge clk_i) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= W'(P_PERIOD - 1));
  p_cnt_wrap_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
  p_cnt_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_o |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/dpwm_cmp_latch.sv
module dpwm_cmp_latch
  import dpwm_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 wrap_i,
  input  logic [MAX_BITS-1:0]  duty_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic                 inc_i,
  output logic                 req_o,
  output logic [DBG_W-1:0]     dbg_o
);
  logic [CNT_W-1:0]    cmp_q;
  logic [MAX_BITS-1:0] norm_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmp_q  <= '0;
      norm_q <= '0;
    end else if (wrap_i) begin
      cmp_q  <= cmp_value(duty_i, sel_i, inc_i);
      norm_q <= MAX_BITS'(norm_duty(duty_i, sel_i));
    end
  end

  assign req_o = (cnt_i < cmp_q);
  assign dbg_o = norm_q[MAX_BITS-1 -: DBG_W];

  p_cmp_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap_i |=> $stable(cmp_q));
  p_cmp_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_q <= CNT_W'(PERIOD));
  p_cmp_nonzero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_i |=> (cmp_q != '0));
endmodule

// File: rtl/dpwm_deadtime.sv
module dpwm_deadtime #(
  parameter int P_DEAD = 6,
  localparam int DW = $clog2(P_DEAD + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic hs_o,
  output logic ls_o
);
  logic          lvl_q;
  logic [DW-1:0] dt_q;
  logic          settled;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      dt_q  <= DW'(P_DEAD);
    end else if (req_i != lvl_q) begin
      lvl_q <= req_i;
      dt_q  <= DW'(P_DEAD);
    end else if (dt_q != '0) begin
      dt_q  <= dt_q - 1'b1;
    end
  end

  assign settled = (dt_q == '0);
  assign hs_o    = lvl_q & settled;
  assign ls_o    = ~lvl_q & settled;

  p_no_overlap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hs_o && ls_o));
  p_gap_after_hs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(hs_o) |=> !ls_o);
  p_gap_after_ls_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ls_o) |=> !hs_o);
  p_reset_low_r7: assert property (@(posedge clk_i)
    !rst_ni |=> (!hs_o && !ls_o));
endmodule

// File: rtl/dpwm_core.sv
module dpwm_core
  import dpwm_pkg::*;
#(
  parameter int DEAD = 6
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [MAX_BITS-1:0] duty_i,
  input  logic [SEL_W-1:0]    width_sel_i,
  input  logic                inc_i,
  output logic                hs_o,
  output logic                ls_o,
  output logic                sync_o,
  output logic [DBG_W-1:0]    duty_dbg_o
);
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             req;

  dpwm_period_ctr #(.P_PERIOD(PERIOD)) u_ctr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .wrap_o(wrap),
    .sync_o(sync_o)
  );

  dpwm_cmp_latch u_cmp (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_i (cnt),
    .wrap_i(wrap),
    .duty_i(duty_i),
    .sel_i (width_sel_i),
    .inc_i (inc_i),
    .req_o (req),
    .dbg_o (duty_dbg_o)
  );

  dpwm_deadtime #(.P_DEAD(DEAD)) u_dt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (req),
    .hs_o  (hs_o),
    .ls_o  (ls_o)
  );

  p_sync_fall_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt == CNT_W'(PERIOD / 2)) |=> !sync_o);
  p_sync_rise_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> sync_o);
endmodule

// File: tb/dpwm_core_tb_top.sv
module dpwm_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] duty = '0;
  logic [2:0] sel = '0;
  logic       inc = 1'b0;
  logic       hs, ls, sync;
  logic [4:0] dbg;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  int       m_cnt = 0;
  int       m_cmp = 0;
  int       m_dbg = 0;
  logic [6:0] hist = '0;
  int       pushes = 0;
  int       last_rise = -1;
  int       cyc = 0;
  logic     prev_sync = 1'b0;

  always #4 clk = ~clk;

  dpwm_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .duty_i(duty), .width_sel_i(sel),
    .inc_i(inc), .hs_o(hs), .ls_o(ls), .sync_o(sync), .duty_dbg_o(dbg)
  );

  function automatic int bits_of(int s);
    return (s >= 0 && s <= 4) ? 5 + s : 8;
  endfunction

  function automatic int exp_norm(int d, int s);
    int b = bits_of(s);
    return (d % (2 ** b)) * (2 ** (9 - b));
  endfunction

  function automatic int exp_cmp(int d, int s, int i);
    int b = bits_of(s);
    int off = (b >= 8) ? 1 : 2 ** (8 - b);
    return exp_norm(d, s) + off + i;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // advance one clock, update the model, compare outputs at the falling edge
  task automatic tick(string tag);
    @(posedge clk);
    cyc++;
    hist = {hist[5:0], (m_cnt < m_cmp)};
    pushes++;
    if (m_cnt == 512) begin
      m_cmp = exp_cmp(int'(duty), int'(sel), int'(inc));
      m_dbg = exp_norm(int'(duty), int'(sel)) / 16;
      m_cnt = 0;
    end else begin
      m_cnt++;
    end
    @(negedge clk);
    if (pushes >= 7) begin
      chk(tag, int'(hs), int'(&hist));
      chk(tag, int'(ls), int'(~|hist));
      chk("R6", int'(hs & ls), 0);
    end
    chk("R8", int'(sync), int'(m_cnt < 257));
    chk("R9", int'(dbg), m_dbg);
    if (sync && !prev_sync) begin
      if (last_rise >= 0) chk("R1", cyc - last_rise, 513);
      last_rise = cyc;
    end
    prev_sync = sync;
  endtask

  task automatic run(string tag, int d, int s, int i, int periods, int inc_flip);
    duty = 9'(d);
    sel = 3'(s);
    inc = i[0];
    for (int k = 0; k < periods * 513; k++) begin
      if (inc_flip != 0 && (k % inc_flip) == inc_flip - 1) inc = ~inc;
      tick(tag);
    end
  endtask

  initial begin
    repeat (5) @(negedge clk);
    chk("R7", int'(hs), 0);
    chk("R7", int'(ls), 0);
    chk("R7", int'(dbg), 0);
    chk("R7", int'(sync), 1);
    rst_n = 1'b1;
    prev_sync = 1'b1;
    // R2: every legal width, boundary and patterned duties
    for (int s = 0; s < 5; s++) begin
      run("R2", 0, s, 0, 2, 0);
      run("R2", 1, s, 0, 2, 0);
      run("R2", 2 ** bits_of(s) - 1, s, 0, 2, 0);
      run("R2", 'h0AA % (2 ** bits_of(s)), s, 0, 2, 0);
    end
    // R3: out-of-range selects act as 8 bits
    for (int s = 5; s < 8; s++) begin
      run("R3", 'h0C3, s, 0, 2, 0);
      run("R3", 'h0FF, s, 0, 2, 0);
    end
    // R4: upper bits set beyond the width
    for (int s = 0; s < 4; s++) begin
      run("R4", 'h1FF, s, 0, 2, 0);
      run("R4", 'h155, s, 0, 2, 0);
    end
    // R5: increment held, increment toggling mid-period, full-scale stretch
    run("R5", 'h1FF, 4, 1, 2, 0);
    run("R5", 'h07, 0, 1, 2, 0);
    run("R5", 'h40, 3, 0, 4, 171);
    // 9-bit sweep with increment alternating every period
    for (int d = 0; d < 512; d += 37) run("R2", d, 4, (d / 37) % 2, 1, 0);
    // R7: reset mid-run clears outputs again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R7", int'(hs), 0);
    chk("R7", int'(ls), 0);
    chk("R7", int'(dbg), 0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule